// File: doc/BRIEF.md
# Banked Subregister Register File

This block holds the general registers of a 16-bit datapath: sixteen 16-bit words in one physical array. Each access port carries a size selector, so the same storage can be used as sixteen bytes taken from the first eight words, as sixteen words, as eight 32-bit pairs on even boundaries, or as four 64-bit quads. The block has one write port and two read ports. Reads are combinational and writes take effect at the rising clock edge.

Word 15 is the stack pointer and word 14 holds its segment. The pair at index 14 therefore forms a 32-bit address operand, and the block also drives that value on a dedicated output. Two copies of word 15 exist, one for system mode and one for user mode. The mode input selects which copy every port sees, including the stack-address output and any pair or quad that contains word 15.

Top module: `subreg_file`

## Requirements
- R1: An active-low reset clears all fifteen shared words and both stack copies to zero.
- R2: With size code 1 (word), the specifier selects word 0..15. A read returns the word in bits 15:0 with the upper bits zero, and a write stores bits 15:0 of the write data.
- R3: With size code 0 (byte), specifiers 0..7 select the high byte of words 0..7 and specifiers 8..15 select the low byte of words 0..7. A read returns the byte zero-extended. A write stores bits 7:0 of the write data and changes only the target byte.
- R4: With size code 2 (pair), an even specifier n selects words n and n+1, with word n in bits 31:16 and word n+1 in bits 15:0. A pair write updates both words at the same edge.
- R5: With size code 3 (quad), a specifier that is a multiple of four selects words n..n+3, with word n in bits 63:48 down to word n+3 in bits 15:0.
- R6: An odd pair specifier or a quad specifier that is not a multiple of four is illegal. A read port then raises its illegal flag and returns zero. An illegal write raises the write-illegal flag and changes no storage.
- R7: Word 15 is banked. With the mode input at 1 (system), every port uses the system copy, and with 0 (user) every port uses the user copy. A write that reaches word 15 leaves the other copy unchanged.
- R8: The stack-address output always equals word 14 in bits 31:16 and the word 15 copy for the current mode in bits 15:0.
- R9: A read in the cycle of a write to the same location returns the value from before the write, and the new value is visible after the edge.
- R10: The two read ports decode independently, so each can use a different size and specifier in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_mode | input | 1 | 1 = system mode, 0 = user mode |
| wr_en | input | 1 | Write request |
| wr_size | input | 2 | Write size: 0 byte, 1 word, 2 pair, 3 quad |
| wr_idx | input | 4 | Write specifier |
| wr_data | input | 64 | Write data, right-aligned |
| wr_bad | output | 1 | Write specifier misaligned; write dropped |
| rda_size | input | 2 | Port A size code |
| rda_idx | input | 4 | Port A specifier |
| rda_data | output | 64 | Port A data, right-aligned |
| rda_bad | output | 1 | Port A specifier misaligned |
| rdb_size | input | 2 | Port B size code |
| rdb_idx | input | 4 | Port B specifier |
| rdb_data | output | 64 | Port B data, right-aligned |
| rdb_bad | output | 1 | Port B specifier misaligned |
| sp_addr | output | 32 | Segment word and current stack word |

## Verification
The bench targets the aliasing edges. It writes a high byte and then a low byte of the same word, and write data with set upper bits, so a design that swapped the byte halves or merged the whole word would corrupt the neighbour byte. It uses pair and quad writes whose half order a reversed design would store mirrored, and misaligned pair and quad writes that a design rounding the low specifier bits down would let through to the aligned group. It writes the stack word in user mode through word, pair and quad sizes, and a design without per-mode steering would then overwrite the system copy. A read taken in the same cycle as its write would expose a design that forwards write data.

// File: rtl/subreg_file.sv
module subreg_file #(
  parameter int W      = 16,
  parameter int NREG   = 16,
  parameter int NBYTE  = 8,
  parameter int DW     = 4 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_size,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          wr_bad,
  input  logic [1:0]    rda_size,
  input  logic [3:0]    rda_idx,
  output logic [DW-1:0] rda_data,
  output logic          rda_bad,
  input  logic [1:0]    rdb_size,
  input  logic [3:0]    rdb_idx,
  output logic [DW-1:0] rdb_data,
  output logic          rdb_bad,
  output logic [2*W-1:0] sp_addr
);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_PAIR = 2'd2;
  localparam logic [1:0] SZ_QUAD = 2'd3;
  localparam int SP = NREG - 1;
  localparam int SEG = NREG - 2;
  localparam int HB = W / 2;

  logic [W-1:0] gpr [0:SP-1];
  logic [W-1:0] sp_sys, sp_usr;
  logic [NREG-1:0][W-1:0] cur;
  logic [NREG-1:0][W-1:0] nxt;
  logic [NREG-1:0]        hit;

  function automatic logic misaligned(input logic [1:0] sz, input logic [3:0] ix);
    return (sz == SZ_PAIR && ix[0]) || (sz == SZ_QUAD && ix[1:0] != 2'b00);
  endfunction

  function automatic logic [DW-1:0] fetch(input logic [1:0] sz, input logic [3:0] ix,
                                          input logic [NREG-1:0][W-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    if (!misaligned(sz, ix)) begin
      case (sz)
        SZ_BYTE: r[HB-1:0] = ix[3] ? v[{1'b0, ix[2:0]}][HB-1:0]
                                   : v[{1'b0, ix[2:0]}][W-1:HB];
        SZ_WORD: r[W-1:0] = v[ix];
        SZ_PAIR: r[2*W-1:0] = {v[{ix[3:1], 1'b0}], v[{ix[3:1], 1'b1}]};
        default: r = {v[{ix[3:2], 2'b00}], v[{ix[3:2], 2'b01}],
                      v[{ix[3:2], 2'b10}], v[{ix[3:2], 2'b11}]};
      endcase
    end
    return r;
  endfunction

  generate
    for (genvar g = 0; g < SP; g++) begin : g_view
      assign cur[g] = gpr[g];
    end
  endgenerate
  assign cur[SP] = sys_mode ? sp_sys : sp_usr;

  assign wr_bad   = wr_en && misaligned(wr_size, wr_idx);
  assign rda_bad  = misaligned(rda_size, rda_idx);
  assign rdb_bad  = misaligned(rdb_size, rdb_idx);
  assign rda_data = fetch(rda_size, rda_idx, cur);
  assign rdb_data = fetch(rdb_size, rdb_idx, cur);
  assign sp_addr  = {cur[SEG], cur[SP]};

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      logic [3:0] kk;
      kk = 4'(k);
      hit[k] = 1'b0;
      nxt[k] = cur[k];
      if (wr_en && !wr_bad) begin
        case (wr_size)
          SZ_BYTE: if (k < NBYTE && wr_idx[2:0] == kk[2:0]) begin
            hit[k] = 1'b1;
            if (wr_idx[3]) nxt[k][HB-1:0] = wr_data[HB-1:0];
            else           nxt[k][W-1:HB] = wr_data[HB-1:0];
          end
          SZ_WORD: if (wr_idx == kk) begin
            hit[k] = 1'b1;
            nxt[k] = wr_data[W-1:0];
          end
          SZ_PAIR: if (wr_idx[3:1] == kk[3:1]) begin
            hit[k] = 1'b1;
            nxt[k] = kk[0] ? wr_data[W-1:0] : wr_data[2*W-1:W];
          end
          default: if (wr_idx[3:2] == kk[3:2]) begin
            hit[k] = 1'b1;
            nxt[k] = wr_data[(3 - int'(kk[1:0])) * W +: W];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SP; k++) gpr[k] <= '0;
      sp_sys <= '0;
      sp_usr <= '0;
    end else begin
      for (int k = 0; k < SP; k++)
        if (hit[k]) gpr[k] <= nxt[k];
      if (hit[SP]) begin
        if (sys_mode) sp_sys <= nxt[SP];
        else          sp_usr <= nxt[SP];
      end
    end
  end
endmodule

// File: rtl/subreg_file_chk.sv
module subreg_file_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sys_mode,
  input logic        wr_en,
  input logic [1:0]  wr_size,
  input logic [3:0]  wr_idx,
  input logic [63:0] wr_data,
  input logic        wr_bad,
  input logic [1:0]  rda_size,
  input logic [3:0]  rda_idx,
  input logic [63:0] rda_data,
  input logic        rda_bad,
  input logic [1:0]  rdb_size,
  input logic [3:0]  rdb_idx,
  input logic [63:0] rdb_data,
  input logic        rdb_bad,
  input logic [31:0] sp_addr
);
  p_byte_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rda_size == 2'd0 |-> rda_data[63:8] == 56'd0);

  p_word_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdb_size == 2'd1 |-> rdb_data[63:16] == 48'd0);

  p_pair_halves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_size == 2'd2 && !rda_idx[0] && rdb_size == 2'd1 && rdb_idx == rda_idx)
    |-> rda_data[31:16] == rdb_data[15:0]);

  p_bad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rda_bad |-> rda_data == 64'd0);

  p_bad_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_bad);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_bad) ##1 ($stable(rda_size) && $stable(rda_idx) && $stable(sys_mode))
    |-> $stable(rda_data));

  p_seg_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_size == 2'd1 && rda_idx == 4'd14) |-> rda_data[15:0] == sp_addr[31:16]);

  p_stack_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdb_size == 2'd1 && rdb_idx == 4'd15) |-> rdb_data[15:0] == sp_addr[15:0]);
endmodule

bind subreg_file subreg_file_chk u_chk (.*);

// File: tb/test_subreg_file.sv
`timescale 1ns/1ps
module test_subreg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_mode = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd1;
  logic [3:0]  wr_idx = 4'd0;
  logic [63:0] wr_data = 64'd0;
  logic        wr_bad;
  logic [1:0]  rda_size = 2'd1;
  logic [3:0]  rda_idx = 4'd0;
  logic [63:0] rda_data;
  logic        rda_bad;
  logic [1:0]  rdb_size = 2'd1;
  logic [3:0]  rdb_idx = 4'd0;
  logic [63:0] rdb_data;
  logic        rdb_bad;
  logic [31:0] sp_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  subreg_file i_subreg_file (.*);

  function automatic logic [15:0] fw(input int k);
    return 16'hA000 | 16'(k * 16'h0111);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [3:0] ix, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_size = sz; wr_idx = ix; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [1:0] sz, input logic [3:0] ix, output logic [63:0] d);
    @(negedge clk);
    rda_size = sz; rda_idx = ix;
    #1 d = rda_data;
  endtask

  task automatic rd_b(input logic [1:0] sz, input logic [3:0] ix, output logic [63:0] d);
    @(negedge clk);
    rdb_size = sz; rdb_idx = ix;
    #1 d = rdb_data;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    sys_mode = 1'b1;
    for (int k = 0; k < 16; k++) begin
      rd_a(2'd1, 4'(k), d);
      chk("R1 word after reset", d, 64'd0);
    end
    sys_mode = 1'b0;
    rd_a(2'd1, 4'd15, d);
    chk("R1 user stack after reset", d, 64'd0);
    chk("R1 sp_addr after reset", 64'(sp_addr), 64'd0);
    sys_mode = 1'b1;
  endtask

  task automatic t_words();
    logic [63:0] d;
    for (int k = 0; k < 16; k++) wr(2'd1, 4'(k), {48'hFFFF_FFFF_FFFF, fw(k)});
    for (int k = 0; k < 16; k++) begin
      rd_a(2'd1, 4'(k), d);
      chk("R2 word port A", d, 64'(fw(k)));
      rd_b(2'd1, 4'(15 - k), d);
      chk("R10 word port B", d, 64'(fw(15 - k)));
    end
    sys_mode = 1'b0;
    rd_a(2'd1, 4'd15, d);
    chk("R7 user copy untouched by system write", d, 64'd0);
    sys_mode = 1'b1;
  endtask

  task automatic t_bytes();
    logic [63:0] d;
    wr(2'd1, 4'd3, 64'hA1B2);
    wr(2'd0, 4'd3, 64'hFFFF_FFFF_FFFF_FFCC);
    rd_a(2'd1, 4'd3, d);
    chk("R3 high byte write", d, 64'hCCB2);
    wr(2'd0, 4'd11, 64'h0000_0000_0000_FF5D);
    rd_a(2'd1, 4'd3, d);
    chk("R3 low byte write", d, 64'hCC5D);
    rd_a(2'd0, 4'd3, d);
    chk("R3 high byte read", d, 64'hCC);
    rd_b(2'd0, 4'd11, d);
    chk("R3 low byte read", d, 64'h5D);
    rd_a(2'd1, 4'd2, d);
    chk("R3 neighbour below", d, 64'(fw(2)));
    rd_a(2'd1, 4'd11, d);
    chk("R3 word 11 unaffected", d, 64'(fw(11)));
  endtask

  task automatic t_pairs();
    logic [63:0] d;
    wr(2'd2, 4'd4, 64'hFFFF_FFFF_DEAD_BEEF);
    rd_a(2'd1, 4'd4, d);
    chk("R4 even word is high half", d, 64'hDEAD);
    rd_a(2'd1, 4'd5, d);
    chk("R4 odd word is low half", d, 64'hBEEF);
    rd_a(2'd2, 4'd4, d);
    chk("R4 pair read", d, 64'hDEAD_BEEF);
    rd_a(2'd1, 4'd6, d);
    chk("R4 word 6 untouched", d, 64'(fw(6)));
    rd_b(2'd2, 4'd2, d);
    chk("R10 pair on port B", d, {32'd0, fw(2), 16'hCC5D});
  endtask

  task automatic t_quad();
    logic [63:0] d;
    wr(2'd3, 4'd8, 64'h0123_4567_89AB_CDEF);
    rd_a(2'd1, 4'd8, d);  chk("R5 quad word 8", d, 64'h0123);
    rd_a(2'd1, 4'd9, d);  chk("R5 quad word 9", d, 64'h4567);
    rd_a(2'd1, 4'd10, d); chk("R5 quad word 10", d, 64'h89AB);
    rd_a(2'd1, 4'd11, d); chk("R5 quad word 11", d, 64'hCDEF);
    rd_a(2'd3, 4'd8, d);  chk("R5 quad read", d, 64'h0123_4567_89AB_CDEF);
    rd_a(2'd1, 4'd12, d); chk("R5 word 12 untouched", d, 64'(fw(12)));
    rd_b(2'd3, 4'd0, d);
    chk("R5 quad 0 on port B", d, {fw(0), fw(1), fw(2), 16'hCC5D});
  endtask

  task automatic t_misaligned();
    logic [63:0] d;
    @(negedge clk);
    wr_en = 1'b1; wr_size = 2'd2; wr_idx = 4'd5; wr_data = '1;
    #1 chk("R6 wr_bad on odd pair", 64'(wr_bad), 64'd1);
    @(posedge clk);
    #1 wr_en = 1'b0;
    rd_a(2'd1, 4'd4, d); chk("R6 word 4 kept", d, 64'hDEAD);
    rd_a(2'd1, 4'd5, d); chk("R6 word 5 kept", d, 64'hBEEF);
    rd_a(2'd1, 4'd6, d); chk("R6 word 6 kept", d, 64'(fw(6)));
    wr(2'd3, 4'd9, '1);
    rd_a(2'd3, 4'd8, d); chk("R6 quad 8 kept", d, 64'h0123_4567_89AB_CDEF);
    rd_a(2'd2, 4'd5, d);
    chk("R6 odd pair read zero", d, 64'd0);
    chk("R6 odd pair flag", 64'(rda_bad), 64'd1);
    rd_b(2'd3, 4'd6, d);
    chk("R6 quad 6 read zero", d, 64'd0);
    chk("R6 quad 6 flag", 64'(rdb_bad), 64'd1);
    rd_b(2'd2, 4'd6, d);
    chk("R6 aligned pair no flag", 64'(rdb_bad), 64'd0);
    wr_en = 1'b0;
    #1 chk("R6 no write flag when idle", 64'(wr_bad), 64'd0);
  endtask

  task automatic t_bank();
    logic [63:0] d;
    sys_mode = 1'b0;
    wr(2'd1, 4'd15, 64'h7E57);
    rd_a(2'd1, 4'd15, d); chk("R7 user stack", d, 64'h7E57);
    chk("R8 sp_addr user", 64'(sp_addr), {32'd0, fw(14), 16'h7E57});
    rd_b(2'd2, 4'd14, d); chk("R8 pair 14 user", d, {32'd0, fw(14), 16'h7E57});
    sys_mode = 1'b1;
    rd_a(2'd1, 4'd15, d); chk("R7 system stack kept", d, 64'(fw(15)));
    chk("R8 sp_addr system", 64'(sp_addr), {32'd0, fw(14), fw(15)});
    sys_mode = 1'b0;
    wr(2'd2, 4'd14, 64'h1234_5678);
    chk("R8 sp_addr after user pair", 64'(sp_addr), 64'h1234_5678);
    sys_mode = 1'b1;
    #1 chk("R7 system after user pair", 64'(sp_addr), {32'd0, 16'h1234, fw(15)});
    sys_mode = 1'b0;
    wr(2'd3, 4'd12, 64'h1111_2222_3333_4444);
    rd_a(2'd3, 4'd12, d); chk("R7 user quad 12", d, 64'h1111_2222_3333_4444);
    sys_mode = 1'b1;
    rd_a(2'd3, 4'd12, d);
    chk("R7 system quad 12", d, {48'h1111_2222_3333, fw(15)});
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    sys_mode = 1'b1;
    rda_size = 2'd1; rda_idx = 4'd7;
    wr_en = 1'b1; wr_size = 2'd1; wr_idx = 4'd7; wr_data = 64'h0BAD;
    #1 chk("R9 old value in write cycle", rda_data, 64'(fw(7)));
    @(posedge clk);
    #1 wr_en = 1'b0;
    chk("R9 new value after edge", rda_data, 64'h0BAD);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_words();
    t_bytes();
    t_pairs();
    t_quad();
    t_misaligned();
    t_bank();
    t_same_cycle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule